// File: doc/BRIEF.md
# Programmable 16-bit Timer Channel with Target Compare

This block is one timer channel. A 16-bit counter advances on a selected count enable and is compared against a programmable target value. When the count meets the target, or rolls over from 0xFFFF to zero, the channel sets sticky flags and can send a one-cycle interrupt request to an external interrupt controller. Software reaches three registers through a small register port: the count, the mode/status word and the target.

The mode word picks the behaviour. One bit makes the count go back to zero after it meets the target. Two bits enable the interrupt for each kind of event. One bit chooses between an interrupt on every event and a single interrupt that stays suppressed until the mode word is written again. The channel kind is fixed by a parameter. Kinds 0 and 1 can take their count enable from an external pulse input. Kind 2 can count every eighth system clock and has a halt bit. Reading the mode word returns the sticky flags and clears them. Writing the mode word zeroes the count and re-arms the single-shot interrupt.

Top module: `tmr16_channel`

## Requirements
- R1: After reset the count, mode word and target all read 0, and `irq` is low.
- R2: The count rises by exactly one for each enabled count tick and holds while no tick arrives. A write to the count register (`reg_sel`=0) loads `wr_data` directly.
- R3: With mode bit 3 set, a count equal to the target returns to 0 on the next tick. With bit 3 clear, the count runs on to 0xFFFF and wraps to 0.
- R4: When a tick brings the count to the target value, status bits 11 and 10 of the mode word (`reg_sel`=1) are set. If mode bit 4 is set, `irq` pulses in the cycle after that tick.
- R5: When a tick wraps the count from 0xFFFF to 0, status bits 12 and 10 are set. If mode bit 5 is set, `irq` pulses in the cycle after that tick.
- R6: With mode bit 6 set, every enabled event raises `irq`. With bit 6 clear, only the first event after a mode write raises it.
- R7: A mode read (`rd_en` with `reg_sel`=1) returns the current word and then clears bits 11 and 12. Bit 10 is kept.
- R8: A mode write zeroes the count, clears status bits 10 to 12 and re-arms the single-shot interrupt.
- R9: A target write (`reg_sel`=2) leaves the count unchanged. Later compares use the new target.
- R10: In kinds 0 and 1, mode bit 8 set makes the count advance only on `ext_tick` pulses. With bit 8 clear, it advances every system clock.
- R11: In kind 2, mode bit 9 makes the count advance once per 8 system clocks, and mode bit 0 stops counting.
- R12: `irq` is a pulse one cycle wide. It is asserted only in the cycle after a count tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 2 | Register select: 0 count, 1 mode/status, 2 target |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; needed only for the clear-on-read of the mode word |
| rd_data | output | 16 | Value of the selected register (combinational) |
| ext_tick | input | 1 | External count-enable pulse |
| irq | output | 1 | Interrupt request pulse |

## Verification
The count register can be read at any cycle, so a wrong count-enable selection or a faulty prescaler phase shows at the next read as a count off by at least one. A missed return to zero shows as a count above the target within one tick. A single-shot latch in the wrong state shows as an extra or missing `irq` pulse, one cycle after the next target or overflow tick. Flags that are set or cleared wrongly appear in the very next mode read. Because a read clears them, the bench reads twice in a row to tell a set flag apart from one that is stuck.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_TARGET = 2'd2
  } tmr_sel_e;

  // mode word field positions
  localparam int unsigned B_HALT     = 0;
  localparam int unsigned B_AUTOZERO = 3;
  localparam int unsigned B_IRQ_TGT  = 4;
  localparam int unsigned B_IRQ_OVF  = 5;
  localparam int unsigned B_IRQ_RPT  = 6;
  localparam int unsigned B_EXT      = 8;
  localparam int unsigned B_DIV8     = 9;
  localparam int unsigned B_EVT      = 10;
  localparam int unsigned B_TGT      = 11;
  localparam int unsigned B_OVF      = 12;
  localparam int unsigned CFG_W      = 10;

endpackage

// File: rtl/tmr16_tick_sel.sv
module tmr16_tick_sel #(
  parameter int unsigned CHAN_KIND = 0,
  parameter int unsigned PRE_W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick_i,
  input  logic sel_ext_i,
  input  logic sel_div_i,
  input  logic halt_i,
  output logic tick_o
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_tick;

  // free-running prescaler
  always_comb begin
    pre_d = pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign pre_tick = &pre_q;

  always_comb begin
    tick_o = 1'b1;
    if (CHAN_KIND == 2) begin
      if (halt_i)         tick_o = 1'b0;
      else if (sel_div_i) tick_o = pre_tick;
    end else if (sel_ext_i) begin
      tick_o = ext_tick_i;
    end
  end

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         zero_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] target_i,
  input  logic         autozero_i,
  output logic [W-1:0] count_o,
  output logic         tgt_evt_o,
  output logic         ovf_evt_o
);

  logic [W-1:0] cnt_q, cnt_d, inc;
  logic         at_tgt;

  assign inc    = cnt_q + {{(W-1){1'b0}}, 1'b1};
  assign at_tgt = autozero_i && (cnt_q == target_i);

  always_comb begin
    cnt_d     = cnt_q;
    tgt_evt_o = 1'b0;
    ovf_evt_o = 1'b0;
    if (zero_i) begin
      cnt_d = '0;
    end else if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i) begin
      ovf_evt_o = &cnt_q;
      if (at_tgt) begin
        cnt_d = '0;
      end else begin
        cnt_d     = inc;
        tgt_evt_o = (inc == target_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/tmr16_status.sv
module tmr16_status
  import tmr16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wr_i,
  input  logic [W-1:0] mode_wdata_i,
  input  logic         mode_rd_i,
  input  logic         tgt_evt_i,
  input  logic         ovf_evt_i,
  output logic [W-1:0] mode_o,
  output logic         irq_o
);

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             evt_q, evt_d;
  logic             tgt_q, tgt_d;
  logic             ovf_q, ovf_d;
  logic             fired_q, fired_d;
  logic             irq_q, irq_d;
  logic             ask;

  assign ask = (tgt_evt_i && cfg_q[B_IRQ_TGT]) || (ovf_evt_i && cfg_q[B_IRQ_OVF]);

  always_comb begin
    cfg_d   = cfg_q;
    evt_d   = evt_q;
    tgt_d   = tgt_q;
    ovf_d   = ovf_q;
    fired_d = fired_q;
    irq_d   = 1'b0;
    if (mode_wr_i) begin
      cfg_d   = mode_wdata_i[CFG_W-1:0];
      evt_d   = 1'b0;
      tgt_d   = 1'b0;
      ovf_d   = 1'b0;
      fired_d = 1'b0;
    end else begin
      irq_d   = ask && (cfg_q[B_IRQ_RPT] || !fired_q);
      fired_d = fired_q || irq_d;
      evt_d   = evt_q || tgt_evt_i || ovf_evt_i;
      tgt_d   = (tgt_q && !mode_rd_i) || tgt_evt_i;
      ovf_d   = (ovf_q && !mode_rd_i) || ovf_evt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      evt_q   <= 1'b0;
      tgt_q   <= 1'b0;
      ovf_q   <= 1'b0;
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      evt_q   <= evt_d;
      tgt_q   <= tgt_d;
      ovf_q   <= ovf_d;
      fired_q <= fired_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    mode_o                = '0;
    mode_o[CFG_W-1:0]     = cfg_q;
    mode_o[B_EVT]         = evt_q;
    mode_o[B_TGT]         = tgt_q;
    mode_o[B_OVF]         = ovf_q;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel
  import tmr16_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter int unsigned CHAN_KIND = 0,
  parameter int unsigned PRE_W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         ext_tick,
  output logic         irq
);

  logic [1:0]   rst_sync_q;
  logic         core_rst_n;
  logic         wr_count, wr_mode, wr_target, rd_mode;
  logic [W-1:0] target_q, target_d;
  logic [W-1:0] mode_w, count_w;
  logic         cnt_tick, tgt_evt, ovf_evt, halt_req;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign wr_count  = wr_en && (reg_sel == SEL_COUNT);
  assign wr_mode   = wr_en && (reg_sel == SEL_MODE);
  assign wr_target = wr_en && (reg_sel == SEL_TARGET);
  assign rd_mode   = rd_en && (reg_sel == SEL_MODE);
  assign halt_req  = (CHAN_KIND == 2) && mode_w[B_HALT];

  always_comb begin
    target_d = target_q;
    if (wr_target) target_d = wr_data;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) target_q <= '0;
    else             target_q <= target_d;
  end

  tmr16_tick_sel #(
    .CHAN_KIND (CHAN_KIND),
    .PRE_W     (PRE_W)
  ) u_tick (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .ext_tick_i (ext_tick),
    .sel_ext_i  (mode_w[B_EXT]),
    .sel_div_i  (mode_w[B_DIV8]),
    .halt_i     (halt_req),
    .tick_o     (cnt_tick)
  );

  tmr16_counter #(.W(W)) u_count (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .tick_i     (cnt_tick),
    .zero_i     (wr_mode),
    .load_i     (wr_count),
    .load_val_i (wr_data),
    .target_i   (target_q),
    .autozero_i (mode_w[B_AUTOZERO]),
    .count_o    (count_w),
    .tgt_evt_o  (tgt_evt),
    .ovf_evt_o  (ovf_evt)
  );

  tmr16_status #(.W(W)) u_status (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .mode_wr_i    (wr_mode),
    .mode_wdata_i (wr_data),
    .mode_rd_i    (rd_mode),
    .tgt_evt_i    (tgt_evt),
    .ovf_evt_i    (ovf_evt),
    .mode_o       (mode_w),
    .irq_o        (irq)
  );

  always_comb begin
    case (reg_sel)
      SEL_COUNT:  rd_data = count_w;
      SEL_MODE:   rd_data = mode_w;
      SEL_TARGET: rd_data = target_q;
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/tmr16_channel_chk.sv
module tmr16_channel_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_tick,
  input logic         wr_count,
  input logic         wr_mode,
  input logic         wr_target,
  input logic         rd_mode,
  input logic         tgt_evt,
  input logic         halt_req,
  input logic [W-1:0] count,
  input logic [W-1:0] mode,
  input logic         irq
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (wr_mode) seen_q <= 1'b0;
    else if (irq)     seen_q <= 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !wr_count && !wr_mode) |=> $stable(count));

  assert_zero_on_mode_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (count == '0));

  assert_single_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !mode[6]) |-> !irq);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && !wr_mode && !tgt_evt) |=> !mode[11]);

  assert_irq_after_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt_tick));

  assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !cnt_tick);

  assert_target_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_target && !cnt_tick && !wr_count && !wr_mode) |=> $stable(count));

endmodule

bind tmr16_channel tmr16_channel_chk u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .cnt_tick  (cnt_tick),
  .wr_count  (wr_count),
  .wr_mode   (wr_mode),
  .wr_target (wr_target),
  .rd_mode   (rd_mode),
  .tgt_evt   (tgt_evt),
  .halt_req  (halt_req),
  .count     (count_w),
  .mode      (mode_w),
  .irq       (irq)
);

// File: tb/test_tmr16_channel.sv
module test_tmr16_channel;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic [15:0] wr_data;
  logic        wr_en0, wr_en2, rd_en0, rd_en2;
  logic [15:0] rd0, rd2;
  logic        ext_tick;
  logic        irq0, irq2;

  int errors = 0;
  int checks = 0;
  int irq_cnt0 = 0;

  tmr16_channel #(.CHAN_KIND(0)) i_tmr16_channel (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en0),
    .wr_data(wr_data), .rd_en(rd_en0), .rd_data(rd0),
    .ext_tick(ext_tick), .irq(irq0)
  );

  tmr16_channel #(.CHAN_KIND(2)) i_tmr16_channel_k2 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en2),
    .wr_data(wr_data), .rd_en(rd_en2), .rd_data(rd2),
    .ext_tick(ext_tick), .irq(irq2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (irq0) irq_cnt0++;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic wr(input bit k2, input logic [1:0] sel, input logic [15:0] d);
    reg_sel = sel; wr_data = d;
    if (k2) wr_en2 = 1'b1; else wr_en0 = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en0 = 1'b0; wr_en2 = 1'b0;
  endtask

  task automatic rd(input bit k2, input logic [1:0] sel, output logic [15:0] v);
    reg_sel = sel;
    if (k2) rd_en2 = 1'b1; else rd_en0 = 1'b1;
    #1 v = k2 ? rd2 : rd0;
    @(posedge clk); @(negedge clk);
    rd_en0 = 1'b0; rd_en2 = 1'b0;
  endtask

  task automatic peek(input bit k2, input logic [1:0] sel, output logic [15:0] v);
    reg_sel = sel;
    #1 v = k2 ? rd2 : rd0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ext_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      ext_tick = 1'b0;
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(0, 2'd0, v); chk("R1 count", v, 16'h0000);
    peek(0, 2'd1, v); chk("R1 mode", v, 16'h0000);
    peek(0, 2'd2, v); chk("R1 target", v, 16'h0000);
    chk("R1 irq", {15'd0, irq0}, 16'h0000);
  endtask

  task automatic t_ext_count();
    logic [15:0] v;
    wr(0, 2'd1, 16'h0100);
    pulse(5);
    peek(0, 2'd0, v); chk("R10 ext ticks", v, 16'd5);
    repeat (6) @(negedge clk);
    peek(0, 2'd0, v); chk("R2 hold without tick", v, 16'd5);
    wr(0, 2'd0, 16'h1234);
    peek(0, 2'd0, v); chk("R2 count load", v, 16'h1234);
  endtask

  task automatic t_target_oneshot();
    logic [15:0] v;
    int base;
    wr(0, 2'd2, 16'd3);
    wr(0, 2'd1, 16'h0118);
    base = irq_cnt0;
    pulse(3);
    peek(0, 2'd0, v); chk("R4 reached target", v, 16'd3);
    chk("R4 irq on target", 16'(irq_cnt0 - base), 16'd1);
    rd(0, 2'd1, v); chk("R4 flags set", v, 16'h0D18);
    rd(0, 2'd1, v); chk("R7 read clears 11", v, 16'h0518);
    pulse(1);
    peek(0, 2'd0, v); chk("R3 autozero", v, 16'd0);
    pulse(3);
    chk("R6 single shot", 16'(irq_cnt0 - base), 16'd1);
    rd(0, 2'd1, v); chk("R6 flag still sets", v, 16'h0D18);
  endtask

  task automatic t_repeat();
    logic [15:0] v;
    int base;
    wr(0, 2'd1, 16'h0158);
    peek(0, 2'd1, v); chk("R8 mode write clears status", v, 16'h0158);
    base = irq_cnt0;
    pulse(7);
    chk("R6 repeat irq", 16'(irq_cnt0 - base), 16'd2);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    int base;
    wr(0, 2'd1, 16'h0120);
    wr(0, 2'd0, 16'hFFFE);
    base = irq_cnt0;
    pulse(1);
    peek(0, 2'd0, v); chk("R3 reach FFFF", v, 16'hFFFF);
    chk("R5 no irq before wrap", 16'(irq_cnt0 - base), 16'd0);
    pulse(1);
    peek(0, 2'd0, v); chk("R3 wrap", v, 16'h0000);
    chk("R5 irq on wrap", 16'(irq_cnt0 - base), 16'd1);
    rd(0, 2'd1, v); chk("R5 overflow flags", v, 16'h1520);
    rd(0, 2'd1, v); chk("R7 read clears 12", v, 16'h0520);
  endtask

  task automatic t_target_write();
    logic [15:0] v;
    int base;
    wr(0, 2'd2, 16'd100);
    wr(0, 2'd1, 16'h0108);
    base = irq_cnt0;
    pulse(5);
    wr(0, 2'd2, 16'd6);
    peek(0, 2'd0, v); chk("R9 count kept", v, 16'd5);
    pulse(1);
    peek(0, 2'd0, v); chk("R9 new target reached", v, 16'd6);
    rd(0, 2'd1, v); chk("R9 target flag", v, 16'h0D08);
    pulse(1);
    peek(0, 2'd0, v); chk("R3 autozero new target", v, 16'd0);
    chk("R4 no irq when bit4 clear", 16'(irq_cnt0 - base), 16'd0);
  endtask

  task automatic t_sysclk();
    logic [15:0] v;
    wr(0, 2'd1, 16'h0000);
    repeat (7) @(posedge clk);
    @(negedge clk);
    peek(0, 2'd0, v); chk("R10 system clock", v, 16'd7);
  endtask

  task automatic t_kind2();
    logic [15:0] v;
    wr(1, 2'd1, 16'h0200);
    repeat (16) @(posedge clk);
    @(negedge clk);
    peek(1, 2'd0, v); chk("R11 divide by 8 (16 clk)", v, 16'd2);
    repeat (24) @(posedge clk);
    @(negedge clk);
    peek(1, 2'd0, v); chk("R11 divide by 8 (40 clk)", v, 16'd5);
    wr(1, 2'd1, 16'h0001);
    repeat (20) @(posedge clk);
    @(negedge clk);
    peek(1, 2'd0, v); chk("R11 halt", v, 16'd0);
    wr(1, 2'd1, 16'h0000);
    repeat (10) @(posedge clk);
    @(negedge clk);
    peek(1, 2'd0, v); chk("R11 full rate", v, 16'd10);
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = 2'd0; wr_data = '0;
    wr_en0 = 1'b0; wr_en2 = 1'b0; rd_en0 = 1'b0; rd_en2 = 1'b0;
    ext_tick = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_ext_count();
    t_target_oneshot();
    t_repeat();
    t_overflow();
    t_target_write();
    t_sysclk();
    t_kind2();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule